// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block gathers up to eight external interrupt pins and turns them into qualified interrupt requests. Every pin first crosses a two-flop synchroniser. A detector then compares the synchronised level with its value one cycle earlier, and each pin's own sense mode decides whether the pin raised an event. The modes are falling edge, rising edge, both edges, low level and high level. An event sets a sticky pending bit.

A pin's request reaches its output line only under three conditions: the pin is unmasked, its priority field is non-zero and the controller is in individual-pin mode. The block also drives one combined line that is the OR of all pin lines. Software reaches six 32-bit registers through a plain address / write-enable / data port. Reads are combinational.

Top module: `extpin_irq_ctrl`

## Requirements
- R1: A pin transition that the pin's sense mode selects sets its pending bit on the third rising clock edge after the new level is presented, and not earlier.
- R2: The sense register (address 0) gives pin n the field whose low bit is 32-(n+1)*SENSE_W. Pin 0 therefore owns the top field. The field values are: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge. Any other value detects nothing.
- R3: In the level modes the pending bit is set again on every cycle the active level persists. A clear written while that level lasts leaves the bit set, and a clear written after the level has gone takes effect.
- R4: The pending register (address 2) shows pin n at bit 31-n. A written 0 clears that pin's bit and a written 1 leaves it unchanged. An event arriving in the same cycle as a clear wins.
- R5: Writing 1 to bit 31-n of the mask-set register (address 3) masks pin n. Writing 1 to bit 31-n of the mask-clear register (address 4) unmasks it. Zero bits have no effect, and both addresses read as zero.
- R6: The priority register (address 1) holds a 4-bit field per pin, with pin n at bits 31-4n down to 28-4n. A zero field blocks that pin's output and any non-zero value passes it.
- R7: irq_o[n] is high exactly when pin n is pending, unmasked, has non-zero priority and individual-pin mode is on. irq_any_o is high when any irq_o bit is high.
- R8: Bit 23 of the mode register (address 5) enables individual-pin mode. While it is 0 all outputs stay low, but pending bits still latch.
- R9: After reset all pins are masked, and the sense, priority, pending and mode registers read zero, with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_o | output | NUM_PINS | Per-pin qualified interrupt lines |
| irq_any_o | output | 1 | OR of all per-pin lines |

## Verification
Each pin change is applied on a falling clock edge. Three rising edges later the pending bit is due: two of those edges are synchroniser stages and one is the pending register. The bench reads the bit on the falling edge after that third rising edge, and for R1 it also reads it one edge earlier to confirm the bit is not yet set. Register writes take effect at the next rising edge. The outputs are combinational from the registers, so every register check and irq check is sampled on the falling edge that follows the write.

// File: rtl/extpin_pkg.sv
`timescale 1ns/1ps
package extpin_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned PRIO_W = 4;

   localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
   localparam logic [ADDR_W-1:0] A_PRIO  = 3'd1;
   localparam logic [ADDR_W-1:0] A_PEND  = 3'd2;
   localparam logic [ADDR_W-1:0] A_MSET  = 3'd3;
   localparam logic [ADDR_W-1:0] A_MCLR  = 3'd4;
   localparam logic [ADDR_W-1:0] A_MODE  = 3'd5;

   localparam logic [3:0] SNS_FALL = 4'd0;
   localparam logic [3:0] SNS_RISE = 4'd1;
   localparam logic [3:0] SNS_LOW  = 4'd2;
   localparam logic [3:0] SNS_HIGH = 4'd3;
   localparam logic [3:0] SNS_BOTH = 4'd4;

   function automatic int unsigned flag_pos(input int unsigned n);
      return REG_W - 1 - n;
   endfunction

   function automatic int unsigned field_lsb(input int unsigned n, input int unsigned w);
      return REG_W - (n + 1) * w;
   endfunction
endpackage

// File: rtl/extpin_sync.sv
`timescale 1ns/1ps
module extpin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/extpin_detect.sv
`timescale 1ns/1ps
module extpin_detect
   import extpin_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned SENSE_W  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_PINS-1:0]               cur_i,
   input  logic [NUM_PINS-1:0][SENSE_W-1:0]  sense_i,
   output logic [NUM_PINS-1:0]               hit_o
);
   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur_i;
   end

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      logic [3:0] mode;
      assign mode = 4'(sense_i[n]);
      always_comb begin
         case (mode)
            SNS_FALL: hit_o[n] =  prev_q[n] & ~cur_i[n];
            SNS_RISE: hit_o[n] = ~prev_q[n] &  cur_i[n];
            SNS_LOW:  hit_o[n] = ~cur_i[n];
            SNS_HIGH: hit_o[n] =  cur_i[n];
            SNS_BOTH: hit_o[n] =  prev_q[n] ^ cur_i[n];
            default:  hit_o[n] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/extpin_regs.sv
`timescale 1ns/1ps
module extpin_regs
   import extpin_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned SENSE_W  = 4,
   parameter bit          HAS_MODE = 1'b1,
   parameter int unsigned MODE_BIT = 23
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic                             we_i,
   input  logic [REG_W-1:0]                 wdata_i,
   input  logic [NUM_PINS-1:0]              hit_i,
   output logic [REG_W-1:0]                 rdata_o,
   output logic [NUM_PINS-1:0][SENSE_W-1:0] sense_o,
   output logic [NUM_PINS-1:0][PRIO_W-1:0]  prio_o,
   output logic [NUM_PINS-1:0]              mask_o,
   output logic [NUM_PINS-1:0]              pend_o,
   output logic                             indiv_o
);
   logic [NUM_PINS-1:0][SENSE_W-1:0] sense_q;
   logic [NUM_PINS-1:0][PRIO_W-1:0]  prio_q;
   logic [NUM_PINS-1:0]              mask_q, pend_q;
   logic wr_sense, wr_prio, wr_pend, wr_mset, wr_mclr, wr_mode;

   assign wr_sense = we_i && (addr_i == A_SENSE);
   assign wr_prio  = we_i && (addr_i == A_PRIO);
   assign wr_pend  = we_i && (addr_i == A_PEND);
   assign wr_mset  = we_i && (addr_i == A_MSET);
   assign wr_mclr  = we_i && (addr_i == A_MCLR);
   assign wr_mode  = we_i && (addr_i == A_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         prio_q  <= '0;
         mask_q  <= '1;
         pend_q  <= '0;
      end else begin
         for (int n = 0; n < NUM_PINS; n++) begin
            if (wr_sense) sense_q[n] <= wdata_i[field_lsb(n, SENSE_W) +: SENSE_W];
            if (wr_prio)  prio_q[n]  <= wdata_i[field_lsb(n, PRIO_W) +: PRIO_W];
            if (wr_mset && wdata_i[flag_pos(n)])      mask_q[n] <= 1'b1;
            else if (wr_mclr && wdata_i[flag_pos(n)]) mask_q[n] <= 1'b0;
            pend_q[n] <= hit_i[n] | (pend_q[n] & ~(wr_pend & ~wdata_i[flag_pos(n)]));
         end
      end
   end

   if (HAS_MODE) begin : g_mode
      logic mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       mode_q <= 1'b0;
         else if (wr_mode) mode_q <= wdata_i[MODE_BIT];
      end
      assign indiv_o = mode_q;
   end else begin : g_no_mode
      assign indiv_o = 1'b1;
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_SENSE: for (int n = 0; n < NUM_PINS; n++)
                     rdata_o[field_lsb(n, SENSE_W) +: SENSE_W] = sense_q[n];
         A_PRIO:  for (int n = 0; n < NUM_PINS; n++)
                     rdata_o[field_lsb(n, PRIO_W) +: PRIO_W] = prio_q[n];
         A_PEND:  for (int n = 0; n < NUM_PINS; n++)
                     rdata_o[flag_pos(n)] = pend_q[n];
         A_MODE:  rdata_o[MODE_BIT] = HAS_MODE & indiv_o;
         default: rdata_o = '0;
      endcase
   end

   assign sense_o = sense_q;
   assign prio_o  = prio_q;
   assign mask_o  = mask_q;
   assign pend_o  = pend_q;
endmodule

// File: rtl/extpin_irq_ctrl.sv
`timescale 1ns/1ps
module extpin_irq_ctrl
   import extpin_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned SENSE_W     = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_MODE    = 1'b1,
   parameter int unsigned MODE_BIT    = 23
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output logic [NUM_PINS-1:0] irq_o,
   output logic                irq_any_o
);
   if (NUM_PINS < 1 || NUM_PINS > 8) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..8");
   end
   if (SENSE_W != 2 && SENSE_W != 4) begin : g_bad_sense
      $error("SENSE_W must be 2 or 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MODE_BIT >= REG_W) begin : g_bad_mode
      $error("MODE_BIT outside register");
   end

   logic [NUM_PINS-1:0]              pin_s, hit, mask_q, pend_q;
   logic [NUM_PINS-1:0][SENSE_W-1:0] sense;
   logic [NUM_PINS-1:0][PRIO_W-1:0]  prio;
   logic                             indiv;

   extpin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s));

   extpin_detect #(.NUM_PINS(NUM_PINS), .SENSE_W(SENSE_W)) u_detect (
      .clk(clk), .rst_n(rst_n), .cur_i(pin_s), .sense_i(sense), .hit_o(hit));

   extpin_regs #(.NUM_PINS(NUM_PINS), .SENSE_W(SENSE_W),
                 .HAS_MODE(HAS_MODE), .MODE_BIT(MODE_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .we_i(reg_we),
      .wdata_i(reg_wdata), .hit_i(hit), .rdata_o(reg_rdata),
      .sense_o(sense), .prio_o(prio), .mask_o(mask_q), .pend_o(pend_q),
      .indiv_o(indiv));

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_out
      assign irq_o[n] = pend_q[n] & ~mask_q[n] & (|prio[n]) & indiv;
   end
   assign irq_any_o = |irq_o;
endmodule

// File: rtl/extpin_irq_ctrl_chk.sv
`timescale 1ns/1ps
module extpin_irq_ctrl_chk
   import extpin_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_we,
   input logic [REG_W-1:0]    reg_wdata,
   input logic [REG_W-1:0]    reg_rdata,
   input logic [NUM_PINS-1:0] irq_o,
   input logic                irq_any_o,
   input logic [NUM_PINS-1:0] pend_i,
   input logic [NUM_PINS-1:0] mask_i,
   input logic [NUM_PINS-1:0] hit_i
);
   p_wo_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_MSET || reg_addr == A_MCLR) |-> reg_rdata == '0);

   p_any_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any_o |-> $countones(irq_o) > 0);

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      p_pend_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
         pend_i[n] && !(reg_we && reg_addr == A_PEND && !reg_wdata[REG_W-1-n])
         |=> pend_i[n]);

      p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         reg_we && reg_addr == A_PEND && !reg_wdata[REG_W-1-n] && !hit_i[n]
         |=> !pend_i[n]);

      p_level_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
         hit_i[n] |=> pend_i[n]);

      p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
         reg_we && reg_addr == A_MSET && reg_wdata[REG_W-1-n] |=> mask_i[n]);

      p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
         reg_we && reg_addr == A_MCLR && reg_wdata[REG_W-1-n] |=> !mask_i[n]);

      p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !(reg_we && (reg_addr == A_MSET || reg_addr == A_MCLR)) |=> $stable(mask_i[n]));

      p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         mask_i[n] |-> !irq_o[n]);

      p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !pend_i[n] |-> !irq_o[n]);
   end
endmodule

bind extpin_irq_ctrl extpin_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
   .irq_any_o(irq_any_o), .pend_i(pend_q), .mask_i(mask_q), .hit_i(hit));

// File: tb/extpin_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module extpin_irq_ctrl_tb_top;
   import extpin_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pins = '0;
   logic [2:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  irq_o;
   logic        irq_any_o;
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   extpin_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .irq_any_o(irq_any_o));

   // {pin[2:0], sense[3:0], level_before, level_after, expected_pending}
   localparam int NVEC = 12;
   localparam logic [9:0] VEC [NVEC] = '{
      {3'd0, 4'd1, 1'b0, 1'b1, 1'b1},
      {3'd0, 4'd1, 1'b1, 1'b0, 1'b0},
      {3'd1, 4'd0, 1'b1, 1'b0, 1'b1},
      {3'd1, 4'd0, 1'b0, 1'b1, 1'b0},
      {3'd2, 4'd4, 1'b0, 1'b1, 1'b1},
      {3'd2, 4'd4, 1'b1, 1'b0, 1'b1},
      {3'd3, 4'd2, 1'b1, 1'b0, 1'b1},
      {3'd4, 4'd3, 1'b0, 1'b1, 1'b1},
      {3'd5, 4'd3, 1'b0, 1'b0, 1'b0},
      {3'd6, 4'd7, 1'b0, 1'b1, 1'b0},
      {3'd7, 4'd1, 1'b0, 1'b1, 1'b1},
      {3'd7, 4'd2, 1'b1, 1'b1, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      #2_000_000;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R9 reset state
      rd(A_SENSE, d); chk("R9 sense", d, 32'h0);
      rd(A_PRIO, d);  chk("R9 prio", d, 32'h0);
      rd(A_PEND, d);  chk("R9 pend", d, 32'h0);
      rd(A_MODE, d);  chk("R9 mode", d, 32'h0);
      chk("R9 irq", {23'h0, irq_any_o, irq_o}, 32'h0);

      // R2 table of sense modes
      for (int i = 0; i < NVEC; i++) begin
         logic [9:0] v;
         int p;
         v = VEC[i];
         p = int'(v[9:7]);
         wr(A_SENSE, 32'(v[6:3]) << (28 - 4 * p));
         pins[p] = v[2];
         cyc(4);
         wr(A_PEND, 32'h0);
         pins[p] = v[1];
         cyc(3);
         rd(A_PEND, d);
         chk($sformatf("R2 vec%0d", i), {31'h0, d[31-p]}, {31'h0, v[0]});
      end
      wr(A_SENSE, 32'h0);
      rd(A_SENSE, d); chk("R2 sense readback", d, 32'h0);
      pins = '0;
      cyc(4);
      wr(A_PEND, 32'h0);

      // R1 latency of a rising edge on pin 0
      wr(A_SENSE, 32'h1000_0000);
      rd(A_SENSE, d); chk("R2 sense field", d, 32'h1000_0000);
      pins[0] = 1'b1;
      cyc(2);
      rd(A_PEND, d); chk("R1 early", d, 32'h0);
      cyc(1);
      rd(A_PEND, d); chk("R1 due", d, 32'h8000_0000);

      // R6 R7 R5 R8 qualification of the output
      wr(A_MODE, 32'h0080_0000);
      chk("R7 masked", {23'h0, irq_any_o, irq_o}, 32'h0);
      wr(A_MCLR, 32'h8000_0000);
      chk("R6 zero prio", {23'h0, irq_any_o, irq_o}, 32'h0);
      wr(A_PRIO, 32'hF000_0000);
      chk("R7 pass", {23'h0, irq_any_o, irq_o}, 32'h101);
      rd(A_PRIO, d); chk("R6 readback", d, 32'hF000_0000);
      wr(A_PRIO, 32'h1000_0000);
      chk("R6 nonzero", {23'h0, irq_any_o, irq_o}, 32'h101);
      wr(A_MSET, 32'h0);
      chk("R5 zero bits", {23'h0, irq_any_o, irq_o}, 32'h101);
      wr(A_MSET, 32'h8000_0000);
      chk("R5 masked", {23'h0, irq_any_o, irq_o}, 32'h0);
      rd(A_MSET, d); chk("R5 mset reads 0", d, 32'h0);
      rd(A_MCLR, d); chk("R5 mclr reads 0", d, 32'h0);
      wr(A_MCLR, 32'h8000_0000);
      chk("R5 unmasked", {23'h0, irq_any_o, irq_o}, 32'h101);
      wr(A_MODE, 32'h0);
      chk("R8 suppressed", {23'h0, irq_any_o, irq_o}, 32'h0);
      rd(A_PEND, d); chk("R8 pend kept", d, 32'h8000_0000);
      rd(A_MODE, d); chk("R8 mode off", d, 32'h0);
      wr(A_MODE, 32'h0080_0000);
      rd(A_MODE, d); chk("R8 mode on", d, 32'h0080_0000);
      chk("R8 restored", {23'h0, irq_any_o, irq_o}, 32'h101);

      // R4 selective and all-ones clear
      wr(A_SENSE, 32'h1000_0001);
      pins[7] = 1'b1;
      cyc(3);
      rd(A_PEND, d); chk("R4 two pending", d, 32'h8100_0000);
      chk("R7 pin7 masked", {23'h0, irq_any_o, irq_o}, 32'h101);
      wr(A_PEND, 32'h7FFF_FFFF);
      rd(A_PEND, d); chk("R4 single clear", d, 32'h0100_0000);
      chk("R7 after clear", {23'h0, irq_any_o, irq_o}, 32'h0);
      wr(A_PEND, 32'hFFFF_FFFF);
      rd(A_PEND, d); chk("R4 ones keep", d, 32'h0100_0000);
      wr(A_PEND, 32'h0);
      rd(A_PEND, d); chk("R4 clear all", d, 32'h0);

      // R3 high level on pin 4 refills pending
      wr(A_SENSE, 32'h0000_3000);
      pins[4] = 1'b1;
      cyc(3);
      wr(A_PEND, 32'h0);
      rd(A_PEND, d); chk("R3 level holds", d, 32'h0800_0000);
      pins[4] = 1'b0;
      cyc(3);
      wr(A_PEND, 32'h0);
      rd(A_PEND, d); chk("R3 level gone", d, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule